// File: doc/BRIEF.md
# Two-Direction Audio Transfer Register Block

This block holds the software-visible control and status state for an audio transfer engine that runs a capture stream and a playback stream at the same time. Software reaches it over a simple 32-bit register bus with separate read and write enables. The read data is registered, so it appears in the cycle after the read request.

For each direction the block keeps a current buffer address and count, and a second "next" pair that software fills in while the current buffer is still being moved. The engine asks for the next pair with a load pulse. A per-direction dirty bit shows whether software has given a fresh next address since the last load.

A single status word does three jobs:

- It collects sticky event flags. The engine raises them with one-cycle strobes and software clears them by writing ones.
- It carries the enables that steer those flags onto one interrupt line.
- It holds the run, pause, codec power-down and self-clearing soft-reset controls, which drive the engine directly.

Top module: `adma_regs`

## Requirements
- R1: Accesses decode word-aligned byte offsets only. The map is:
  - 0: status word.
  - 16, 20, 24, 28: capture current address, current count, next address, next count.
  - 32, 36, 40, 44: the same four registers for playback.
  - Offsets 4, 8 and 12, any offset of 48 or more, and any offset with nonzero low two bits read as zero and ignore writes.
- R2: In the status word these bits are plain read/write:
  - bit 19 global interrupt enable;
  - enables for the playback event (18), capture event (17), error event (16), playback pipe-empty event (12) and capture pipe-empty event (8);
  - playback pause (7), capture pause (6), codec power-down (5), playback run (3) and capture run (2).
  
  The run, pause and power-down bits drive the matching outputs. Bits 31:24, 4 and 1 read as zero.
- R3: Five sticky event flags are set by one-cycle engine strobes and read as 1 while pending: playback event bit 22, capture event bit 21, error event bit 20, playback pipe-empty bit 15 and capture pipe-empty bit 9.
- R4: Writing 1 to an event flag bit of the status word clears that flag. Writing 0 leaves it unchanged.
- R5: When an engine strobe and a software clear hit the same flag in the same cycle, the flag ends up set.
- R6: The interrupt output is 1 exactly when the global enable is 1 and at least one event flag is set together with its own enable. Status bit 23 reads the same value, and writes to bit 23 have no effect.
- R7: A write to a next-address register sets that direction's dirty bit, read back in the status word at bit 13 for playback and bit 10 for capture. A write to a next-count register leaves the dirty bit unchanged.
- R8: A load pulse copies the next address and count into the current registers and clears the dirty bit. A next-address write in the same cycle as a load still leaves the dirty bit set, and the load copies the older next value.
- R9: Two status bits are driven only by the engine, through set and clear inputs, with set winning when both are asserted: playback pipe empty at bit 14 and capture data dropped at bit 11. Bus writes to bits 14, 13, 11 and 10 have no effect.
- R10: Writing 1 to status bit 0 raises the soft-reset output for exactly one cycle. On the following cycle every control, status, address and count register reads zero.
- R11: Count registers keep only their low CNT_W bits, and the upper bits read as zero. Read data changes only in the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Registered read data |
| ev_play_set | input | 1 | Strobe that raises the playback event flag |
| ev_cap_set | input | 1 | Strobe that raises the capture event flag |
| ev_err_set | input | 1 | Strobe that raises the error event flag |
| ev_pempty_set | input | 1 | Strobe that raises the playback pipe-empty event flag |
| ev_cempty_set | input | 1 | Strobe that raises the capture pipe-empty event flag |
| ld_next_cap | input | 1 | Capture load-next pulse |
| ld_next_play | input | 1 | Playback load-next pulse |
| pempty_set | input | 1 | Set playback pipe-empty status |
| pempty_clr | input | 1 | Clear playback pipe-empty status |
| cdrop_set | input | 1 | Set capture data-dropped status |
| cdrop_clr | input | 1 | Clear capture data-dropped status |
| cap_addr | output | 32 | Capture current address |
| cap_cnt | output | CNT_W | Capture current count |
| play_addr | output | 32 | Playback current address |
| play_cnt | output | CNT_W | Playback current count |
| go_cap | output | 1 | Capture run |
| go_play | output | 1 | Playback run |
| pause_cap | output | 1 | Capture pause |
| pause_play | output | 1 | Playback pause |
| codec_pd | output | 1 | Codec power-down |
| chip_rst | output | 1 | One-cycle soft-reset pulse |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with ADDR_W = 8 and CNT_W = 16. The wider address reaches offset 80, which would alias onto the capture address register if decoding looked only at the low bits, so the bench can show that such writes are dropped. The narrow count makes truncation of a full 32-bit write to a count register visible on read-back. Same-cycle collisions get dedicated stimulus: strobe against write-one clear, load against next-address write, and engine set against clear.

// File: rtl/adma_regs_pkg.sv
package adma_regs_pkg;

    localparam int NUM_EV = 5;

    // event indices
    localparam int EV_PLAY   = 0;
    localparam int EV_CAP    = 1;
    localparam int EV_ERR    = 2;
    localparam int EV_PEMPTY = 3;
    localparam int EV_CEMPTY = 4;

    // status word bit positions
    localparam int B_IRQ     = 23;
    localparam int B_GIE     = 19;
    localparam int B_PEMPTY  = 14;
    localparam int B_PDIRTY  = 13;
    localparam int B_CDROP   = 11;
    localparam int B_CDIRTY  = 10;
    localparam int B_PPAUSE  = 7;
    localparam int B_CPAUSE  = 6;
    localparam int B_CODEC   = 5;
    localparam int B_PGO     = 3;
    localparam int B_CGO     = 2;
    localparam int B_SRST    = 0;

    // word indices of the register window
    localparam int W_CSR   = 0;
    localparam int W_CAP   = 4;
    localparam int W_PLAY  = 8;
    localparam int W_LIMIT = 12;

    function automatic int ev_bit(input int i);
        case (i)
            EV_PLAY:   return 22;
            EV_CAP:    return 21;
            EV_ERR:    return 20;
            EV_PEMPTY: return 15;
            default:   return 9;
        endcase
    endfunction

    function automatic int en_bit(input int i);
        case (i)
            EV_PLAY:   return 18;
            EV_CAP:    return 17;
            EV_ERR:    return 16;
            EV_PEMPTY: return 12;
            default:   return 8;
        endcase
    endfunction

    typedef struct packed {
        logic [NUM_EV-1:0] evt;
        logic [NUM_EV-1:0] evt_en;
        logic              gie;
        logic              ppause;
        logic              cpause;
        logic              codec_pd;
        logic              pgo;
        logic              cgo;
        logic              srst;
        logic              pempty;
        logic              cdrop;
    } csr_t;

endpackage

// File: rtl/adma_chan.sv
module adma_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             ld_next,
    output logic [31:0]      cur_addr,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [31:0]      nxt_addr,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic             dirty
);
    typedef struct packed {
        logic [31:0]      cur_addr;
        logic [CNT_W-1:0] cur_cnt;
        logic [31:0]      nxt_addr;
        logic [CNT_W-1:0] nxt_cnt;
        logic             dirty;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_next) begin
            st_d.cur_addr = st_q.nxt_addr;
            st_d.cur_cnt  = st_q.nxt_cnt;
            st_d.dirty    = 1'b0;
        end
        if (wr_en) begin
            case (wr_sel)
                2'd0: st_d.cur_addr = wr_data;
                2'd1: st_d.cur_cnt  = wr_data[CNT_W-1:0];
                2'd2: begin
                    st_d.nxt_addr = wr_data;
                    st_d.dirty    = 1'b1;
                end
                default: st_d.nxt_cnt = wr_data[CNT_W-1:0];
            endcase
        end
        if (soft_clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr = st_q.cur_addr;
    assign cur_cnt  = st_q.cur_cnt;
    assign nxt_addr = st_q.nxt_addr;
    assign nxt_cnt  = st_q.nxt_cnt;
    assign dirty    = st_q.dirty;
endmodule

// File: rtl/adma_csr.sv
module adma_csr
    import adma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [NUM_EV-1:0] ev_set,
    input  logic              pempty_set,
    input  logic              pempty_clr,
    input  logic              cdrop_set,
    input  logic              cdrop_clr,
    input  logic              dirty_play,
    input  logic              dirty_cap,
    output logic [31:0]       csr_word,
    output logic              irq,
    output logic              go_cap,
    output logic              go_play,
    output logic              pause_cap,
    output logic              pause_play,
    output logic              codec_pd,
    output logic              chip_rst
);
    csr_t st_d, st_q;

    logic unused_wbits;
    assign unused_wbits = ^{wr_data[31:23], wr_data[14:13], wr_data[11:10],
                            wr_data[4], wr_data[1]};

    always_comb begin
        st_d = st_q;
        if (st_q.srst) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NUM_EV; i++) begin
                st_d.evt[i] = ev_set[i] |
                              (st_q.evt[i] & ~(wr_en & wr_data[ev_bit(i)]));
            end
            if (wr_en) begin
                for (int i = 0; i < NUM_EV; i++)
                    st_d.evt_en[i] = wr_data[en_bit(i)];
                st_d.gie      = wr_data[B_GIE];
                st_d.ppause   = wr_data[B_PPAUSE];
                st_d.cpause   = wr_data[B_CPAUSE];
                st_d.codec_pd = wr_data[B_CODEC];
                st_d.pgo      = wr_data[B_PGO];
                st_d.cgo      = wr_data[B_CGO];
            end
            st_d.srst   = wr_en & wr_data[B_SRST];
            st_d.pempty = pempty_set | (st_q.pempty & ~pempty_clr);
            st_d.cdrop  = cdrop_set  | (st_q.cdrop  & ~cdrop_clr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.gie & (|(st_q.evt & st_q.evt_en));

    always_comb begin
        csr_word = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            csr_word[ev_bit(i)] = st_q.evt[i];
            csr_word[en_bit(i)] = st_q.evt_en[i];
        end
        csr_word[B_IRQ]    = irq;
        csr_word[B_GIE]    = st_q.gie;
        csr_word[B_PEMPTY] = st_q.pempty;
        csr_word[B_PDIRTY] = dirty_play;
        csr_word[B_CDROP]  = st_q.cdrop;
        csr_word[B_CDIRTY] = dirty_cap;
        csr_word[B_PPAUSE] = st_q.ppause;
        csr_word[B_CPAUSE] = st_q.cpause;
        csr_word[B_CODEC]  = st_q.codec_pd;
        csr_word[B_PGO]    = st_q.pgo;
        csr_word[B_CGO]    = st_q.cgo;
        csr_word[B_SRST]   = st_q.srst;
    end

    assign go_cap     = st_q.cgo;
    assign go_play    = st_q.pgo;
    assign pause_cap  = st_q.cpause;
    assign pause_play = st_q.ppause;
    assign codec_pd   = st_q.codec_pd;
    assign chip_rst   = st_q.srst;
endmodule

// File: rtl/adma_regs.sv
module adma_regs
    import adma_regs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              ev_play_set,
    input  logic              ev_cap_set,
    input  logic              ev_err_set,
    input  logic              ev_pempty_set,
    input  logic              ev_cempty_set,
    input  logic              ld_next_cap,
    input  logic              ld_next_play,
    input  logic              pempty_set,
    input  logic              pempty_clr,
    input  logic              cdrop_set,
    input  logic              cdrop_clr,
    output logic [31:0]       cap_addr,
    output logic [CNT_W-1:0]  cap_cnt,
    output logic [31:0]       play_addr,
    output logic [CNT_W-1:0]  play_cnt,
    output logic              go_cap,
    output logic              go_play,
    output logic              pause_cap,
    output logic              pause_play,
    output logic              codec_pd,
    output logic              chip_rst,
    output logic              irq
);
    localparam int IW     = ADDR_W - 2;
    localparam int NUM_CH = 2;   // 0 capture, 1 playback

    logic [IW-1:0] widx;
    logic          aligned;
    logic          csr_hit;
    logic [31:0]   csr_word;

    logic [31:0]      ch_cur_addr [NUM_CH];
    logic [CNT_W-1:0] ch_cur_cnt  [NUM_CH];
    logic [31:0]      ch_nxt_addr [NUM_CH];
    logic [CNT_W-1:0] ch_nxt_cnt  [NUM_CH];
    logic [NUM_CH-1:0] ch_dirty;
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] ch_ld;
    logic [31:0]       ch_rd [NUM_CH];

    logic [31:0] rdata_d, rdata_q;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign csr_hit = aligned && (widx == IW'(W_CSR));
    assign ch_ld   = {ld_next_play, ld_next_cap};

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int BASE = W_CAP + 4 * c;
            assign ch_hit[c] = aligned && (widx >= IW'(BASE)) &&
                               (widx < IW'(BASE + 4));

            adma_chan #(.CNT_W(CNT_W)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .soft_clr (chip_rst),
                .wr_en    (bus_we && ch_hit[c]),
                .wr_sel   (widx[1:0]),
                .wr_data  (bus_wdata),
                .ld_next  (ch_ld[c]),
                .cur_addr (ch_cur_addr[c]),
                .cur_cnt  (ch_cur_cnt[c]),
                .nxt_addr (ch_nxt_addr[c]),
                .nxt_cnt  (ch_nxt_cnt[c]),
                .dirty    (ch_dirty[c])
            );

            always_comb begin
                case (widx[1:0])
                    2'd0:    ch_rd[c] = ch_cur_addr[c];
                    2'd1:    ch_rd[c] = 32'(ch_cur_cnt[c]);
                    2'd2:    ch_rd[c] = ch_nxt_addr[c];
                    default: ch_rd[c] = 32'(ch_nxt_cnt[c]);
                endcase
            end
        end
    endgenerate

    adma_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we && csr_hit),
        .wr_data    (bus_wdata),
        .ev_set     ({ev_cempty_set, ev_pempty_set, ev_err_set,
                      ev_cap_set, ev_play_set}),
        .pempty_set (pempty_set),
        .pempty_clr (pempty_clr),
        .cdrop_set  (cdrop_set),
        .cdrop_clr  (cdrop_clr),
        .dirty_play (ch_dirty[1]),
        .dirty_cap  (ch_dirty[0]),
        .csr_word   (csr_word),
        .irq        (irq),
        .go_cap     (go_cap),
        .go_play    (go_play),
        .pause_cap  (pause_cap),
        .pause_play (pause_play),
        .codec_pd   (codec_pd),
        .chip_rst   (chip_rst)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (bus_re) begin
            if (csr_hit)        rdata_d = csr_word;
            else if (ch_hit[0]) rdata_d = ch_rd[0];
            else if (ch_hit[1]) rdata_d = ch_rd[1];
            else                rdata_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign bus_rdata = rdata_q;
    assign cap_addr  = ch_cur_addr[0];
    assign cap_cnt   = ch_cur_cnt[0];
    assign play_addr = ch_cur_addr[1];
    assign play_cnt  = ch_cur_cnt[1];
endmodule

// File: rtl/adma_regs_chk.sv
module adma_regs_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              ev_cap_set,
    input logic              ld_next_cap,
    input logic [31:0]       csr_word,
    input logic              chip_rst,
    input logic              irq
);
    logic wr_csr, wr_cnext;
    assign wr_csr   = bus_we && (bus_addr == ADDR_W'(0));
    assign wr_cnext = bus_we && (bus_addr == ADDR_W'(24));

    // R3
    cap_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cap_set && !chip_rst) |=> csr_word[21]);

    // R4
    cap_flag_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_csr && bus_wdata[21] && !ev_cap_set) |=> !csr_word[21]);

    // R6
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_word[19] |-> !irq);

    // R7
    dirty_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnext && !chip_rst) |=> csr_word[10]);

    // R8
    dirty_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_next_cap && !wr_cnext) |=> !csr_word[10]);

    // R10
    soft_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> (!chip_rst && csr_word == 32'd0));
endmodule

bind adma_regs adma_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ev_cap_set  (ev_cap_set),
    .ld_next_cap (ld_next_cap),
    .csr_word    (csr_word),
    .chip_rst    (chip_rst),
    .irq         (irq)
);

// File: tb/adma_regs_bench.sv
module adma_regs_bench;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [ADDR_W-1:0] bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  evb = '0;
    logic        ld_cap = 1'b0, ld_play = 1'b0;
    logic        pe_set = 1'b0, pe_clr = 1'b0, cd_set = 1'b0, cd_clr = 1'b0;
    logic [31:0] cap_addr, play_addr;
    logic [CNT_W-1:0] cap_cnt, play_cnt;
    logic go_cap, go_play, pause_cap, pause_play, codec_pd, chip_rst, irq;

    adma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_adma_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .ev_play_set(evb[0]), .ev_cap_set(evb[1]), .ev_err_set(evb[2]),
        .ev_pempty_set(evb[3]), .ev_cempty_set(evb[4]),
        .ld_next_cap(ld_cap), .ld_next_play(ld_play),
        .pempty_set(pe_set), .pempty_clr(pe_clr),
        .cdrop_set(cd_set), .cdrop_clr(cd_clr),
        .cap_addr(cap_addr), .cap_cnt(cap_cnt),
        .play_addr(play_addr), .play_cnt(play_cnt),
        .go_cap(go_cap), .go_play(go_play), .pause_cap(pause_cap),
        .pause_play(pause_play), .codec_pd(codec_pd),
        .chip_rst(chip_rst), .irq(irq)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int n_chk = 0;
    int n_fail = 0;
    logic re_d = 1'b0;

    always @(posedge clk) re_d <= bus_re;

    // monitor: compare registered read data one cycle after each request
    always @(negedge clk) begin
        if (re_d) begin
            item_t it;
            n_chk++;
            if (sb_q.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected read data: actual %h expected none",
                         bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h",
                             it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_re = 1'b1; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic strobe(input int i);
        @(negedge clk);
        evb[i] = 1'b1;
        @(negedge clk);
        evb = '0;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    localparam logic [31:0] BASE = 32'h000F_11EC;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(0,  32'h0, "R10 reset status word");
        rd(16, 32'h0, "R1 reset capture address");
        chk(irq, 0, "R6 reset irq");

        // R2 read/write control bits, reserved bits read zero
        wr(0, 32'hFFFF_FFFE);
        rd(0, BASE, "R2 control readback");
        chk({go_play, go_cap, pause_play, pause_cap, codec_pd}, 5'b11111,
            "R2 control outputs");
        chk(irq, 0, "R6 no flags no irq");

        // R3 strobe raises flag, R6 irq
        strobe(0);
        rd(0, BASE | 32'h00C0_0000, "R3 playback flag set");
        chk(irq, 1, "R6 irq on enabled flag");

        // R4 write zero keeps, write one clears
        wr(0, BASE);
        rd(0, BASE | 32'h00C0_0000, "R4 write zero keeps flag");
        wr(0, BASE | 32'h0040_0000);
        rd(0, BASE, "R4 write one clears flag");
        chk(irq, 0, "R6 irq drops after clear");

        // R6 global and per-flag enables
        wr(0, 32'h0007_11EC);
        strobe(2);
        rd(0, 32'h0017_11EC, "R6 global enable off");
        chk(irq, 0, "R6 irq gated by global enable");
        wr(0, BASE);
        rd(0, 32'h009F_11EC, "R6 global enable on");
        chk(irq, 1, "R6 irq with error flag");
        wr(0, 32'h000E_11EC);
        chk(irq, 0, "R6 irq gated by own enable");
        rd(0, 32'h001E_11EC, "R6 own enable off");
        wr(0, 32'h001F_11EC);
        rd(0, BASE, "R4 error flag cleared");

        // R3 pipe-empty flags
        strobe(3);
        strobe(4);
        rd(0, 32'h008F_93EC, "R3 pipe-empty flags");
        wr(0, 32'h000F_93EC);
        rd(0, BASE, "R4 pipe-empty flags cleared");

        // R5 set wins over clear
        @(negedge clk);
        evb[1] = 1'b1; bus_we = 1'b1; bus_addr = '0; bus_wdata = BASE | 32'h0020_0000;
        @(negedge clk);
        evb = '0; bus_we = 1'b0;
        rd(0, BASE | 32'h00A0_0000, "R5 strobe beats clear");
        wr(0, BASE | 32'h0020_0000);

        // R1 map, padding, out-of-window; R11 truncation and hold
        wr(4, 32'hFFFF_FFFF);
        rd(4, 32'h0, "R1 pad reads zero");
        rd(0, BASE, "R1 pad write ignored");
        rd(8, 32'h0, "R1 pad 8");
        rd(12, 32'h0, "R1 pad 12");
        wr(16, 32'h1234_5678);
        wr(20, 32'hABCD_EF01);
        wr(32, 32'h0BAD_F00D);
        wr(36, 32'h0000_55AA);
        wr(80, 32'hFFFF_FFFF);
        wr(17, 32'hFFFF_FFFF);
        rd(16, 32'h1234_5678, "R1 capture address");
        rd(20, 32'h0000_EF01, "R11 count truncated");
        chk(cap_addr, 32'h1234_5678, "R1 capture address output");
        rd(36, 32'h0000_55AA, "R1 playback count");
        rd(48, 32'h0, "R1 beyond window");
        rd(80, 32'h0, "R1 no alias");
        rd(32, 32'h0BAD_F00D, "R1 playback address");
        @(negedge clk);
        chk(bus_rdata, 32'h0BAD_F00D, "R11 read data holds");

        // R7 dirty tracking
        wr(28, 32'h0000_1234);
        rd(0, BASE, "R7 count write leaves dirty");
        wr(24, 32'h2000_0000);
        rd(0, BASE | 32'h400, "R7 capture dirty");
        wr(40, 32'h3000_0000);
        wr(44, 32'h0000_0777);
        rd(0, BASE | 32'h2400, "R7 playback dirty");

        // R8 load-next
        @(negedge clk); ld_cap = 1'b1;
        @(negedge clk); ld_cap = 1'b0;
        chk(cap_addr, 32'h2000_0000, "R8 capture address loaded");
        chk(32'(cap_cnt), 32'h1234, "R8 capture count loaded");
        rd(0, BASE | 32'h2000, "R8 capture dirty cleared");
        @(negedge clk);
        ld_play = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(40); bus_wdata = 32'h4000_0000;
        @(negedge clk);
        ld_play = 1'b0; bus_we = 1'b0;
        rd(32, 32'h3000_0000, "R8 playback older next copied");
        rd(36, 32'h0000_0777, "R8 playback count copied");
        rd(40, 32'h4000_0000, "R8 new next kept");
        rd(0, BASE | 32'h2000, "R8 dirty stays on collision");

        // R9 engine-driven status
        @(negedge clk); pe_set = 1'b1;
        @(negedge clk); pe_set = 1'b0; cd_set = 1'b1;
        @(negedge clk); cd_set = 1'b0;
        rd(0, BASE | 32'h6800, "R9 status set");
        wr(0, BASE);
        rd(0, BASE | 32'h6800, "R9 bus write ignored");
        @(negedge clk); pe_set = 1'b1; pe_clr = 1'b1;
        @(negedge clk); pe_set = 1'b0; pe_clr = 1'b0;
        rd(0, BASE | 32'h6800, "R9 set beats clear");
        @(negedge clk); pe_clr = 1'b1; cd_clr = 1'b1;
        @(negedge clk); pe_clr = 1'b0; cd_clr = 1'b0;
        rd(0, BASE | 32'h2000, "R9 status cleared");

        // R10 soft reset
        wr(0, BASE | 32'h1);
        chk(chip_rst, 1, "R10 soft reset pulse");
        @(negedge clk);
        chk(chip_rst, 0, "R10 pulse one cycle");
        chk(go_play, 0, "R10 controls cleared");
        rd(0, 32'h0, "R10 status word cleared");
        rd(16, 32'h0, "R10 capture address cleared");
        rd(40, 32'h0, "R10 playback next cleared");

        @(negedge clk);
        @(negedge clk);
        summary();
    end
endmodule